// File: doc/BRIEF.md
# SPI Chip-Select Controller

This block produces the chip-select lines of an SPI master. It works next to the shift engine and does not touch serial data or the serial clock. A small index picks one of the lines. A polarity input sets the idle level of every line. A mode input chooses one of two ways to drive the selected line:

- **Automatic mode:** the selected line is asserted for the length of a burst. The burst is marked by the engine's busy signal.
- **Manual mode:** the selected line simply takes the level given by software.

In automatic mode the line is asserted one serial half-period before the engine may produce its first clock edge. It is released one half-period after busy drops. The engine supplies a one-cycle strobe at each serial half-period, and this block reports back when the lead time has elapsed. The index is captured when a burst starts, so that software rewriting it mid-burst cannot move the select to another device. All lines are driven from flip-flops, so the outputs never glitch.

Top module: `cs_select_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every line is high (inactive for active-low devices) and `setupDone` is 0.
- R2: Every line other than the selected one is driven to the idle level in every mode. The idle level is 1 when `activeLow` is 1 and 0 when it is 0. At most one line ever differs from the idle level.
- R3: In automatic mode (`manualMode`=0), a `busy`=1 seen while idle drives the line numbered `csIndex` to the asserted level (the inverse of the idle level) from the next clock edge.
- R4: `setupDone` stays 0 after assertion until one `halfTick` strobe has been sampled. It rises at the edge that samples that strobe and stays 1 while `busy` remains 1.
- R5: After `busy` is sampled at 0 during a burst, the line stays asserted and `setupDone` is 0. The line returns to idle at the edge that samples the next `halfTick`.
- R6: In automatic mode the index is captured at the start of a burst. Changes to `csIndex` during the burst do not move the asserted line.
- R7: In manual mode the line numbered by the live `csIndex` is driven to the raw value of `manualLevel`, and `busy` has no effect on any line.
- R8: Every line changes only at a clock edge, one cycle after the inputs that cause the change.
- R9: In manual mode a change of `activeLow` moves all unselected lines to the new idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIndex | input | 2 | Number of the device to select |
| activeLow | input | 1 | 1: lines idle high, assert low; 0: idle low, assert high |
| manualMode | input | 1 | 1: manual drive, 0: automatic burst framing |
| manualLevel | input | 1 | Level for the selected line in manual mode |
| busy | input | 1 | Burst in progress, from the shift engine |
| halfTick | input | 1 | One-cycle strobe per serial half-period |
| csLines | output | 4 | Registered chip-select lines |
| setupDone | output | 1 | Lead time elapsed; engine may clock |

## Verification
The assertions check three things on every cycle:
- At most one line leaves the idle level.
- Manual mode drives the selected line to the past `manualLevel`.
- Every start of a burst follows a sampled `busy`, and `setupDone` rising and the end of a burst each follow a `halfTick`.

Only the bench's scenarios can show the rest. Those behaviours are:
- the exact lead and trail cycle counts;
- the index being held when it is rewritten mid-burst;
- the polarity flip acting on unselected lines;
- the long mixed-mode run, which is compared cycle by cycle against a behavioural model.

// File: rtl/cs_select_pkg.sv
package cs_select_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_HOLD  = 2'd2,
    PH_TRAIL = 2'd3
  } csPhase_t;

  typedef struct packed {
    logic assertSel;
    logic capture;
  } csStrobe_t;

endpackage

// File: rtl/cs_burst_ctrl.sv
module cs_burst_ctrl
  import cs_select_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busy,
  input  logic      manualMode,
  input  logic      halfTick,
  output csStrobe_t strobes,
  output logic      setupDone
);

  csPhase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:  if (busy && !manualMode) phaseNext = PH_LEAD;
      PH_LEAD:  if (halfTick) phaseNext = PH_HOLD;
      PH_HOLD:  if (!busy) phaseNext = PH_TRAIL;
      PH_TRAIL: if (halfTick) phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_comb begin
    strobes.assertSel = (phaseNext != PH_IDLE);
    strobes.capture   = (phase == PH_IDLE) && (phaseNext == PH_LEAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign setupDone = (phase == PH_HOLD);

  logic inBurst;
  assign inBurst = (phase != PH_IDLE);

  // R3
  burst_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inBurst) |-> $past(busy && !manualMode));

  // R4
  setup_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setupDone) |-> $past(halfTick));

  // R5
  release_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inBurst) |-> $past(halfTick));

endmodule

// File: rtl/cs_line_drive.sv
module cs_line_drive
  import cs_select_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  csStrobe_t         strobes,
  input  logic [IDX_W-1:0]  csIndex,
  input  logic              activeLow,
  input  logic              manualMode,
  input  logic              manualLevel,
  output logic [NUM_CS-1:0] csLines
);

  logic [IDX_W-1:0]  heldIdx;
  logic [IDX_W-1:0]  burstIdx;
  logic [NUM_CS-1:0] linesNext;

  assign burstIdx = strobes.capture ? csIndex : heldIdx;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    always_comb begin
      if (manualMode)
        linesNext[g] = (csIndex == IDX_W'(g)) ? manualLevel : activeLow;
      else if (strobes.assertSel && (burstIdx == IDX_W'(g)))
        linesNext[g] = ~activeLow;
      else
        linesNext[g] = activeLow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldIdx <= '0;
      csLines <= '1;
    end else begin
      if (strobes.capture) heldIdx <= csIndex;
      csLines <= linesNext;
    end
  end

  // R2
  single_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($countones(csLines ^ {NUM_CS{$past(activeLow)}}) <= 1));

  // R7
  manual_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(manualMode)) |-> (csLines[$past(csIndex)] == $past(manualLevel)));

endmodule

// File: rtl/cs_select_unit.sv
module cs_select_unit
  import cs_select_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  csIndex,
  input  logic              activeLow,
  input  logic              manualMode,
  input  logic              manualLevel,
  input  logic              busy,
  input  logic              halfTick,
  output logic [NUM_CS-1:0] csLines,
  output logic              setupDone
);

  csStrobe_t strobes;

  cs_burst_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busy       (busy),
    .manualMode (manualMode),
    .halfTick   (halfTick),
    .strobes    (strobes),
    .setupDone  (setupDone)
  );

  cs_line_drive #(.NUM_CS(NUM_CS)) i_drive (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .csIndex     (csIndex),
    .activeLow   (activeLow),
    .manualMode  (manualMode),
    .manualLevel (manualLevel),
    .csLines     (csLines)
  );

endmodule

// File: tb/test_cs_select_unit.sv
module test_cs_select_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] csIndex = '0;
  logic       activeLow = 1'b1;
  logic       manualMode = 1'b0;
  logic       manualLevel = 1'b0;
  logic       busy = 1'b0;
  logic       halfTick = 1'b0;
  logic [3:0] csLines;
  logic       setupDone;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cs_select_unit i_cs_select_unit (
    .clk(clk), .rstN(rstN), .csIndex(csIndex), .activeLow(activeLow),
    .manualMode(manualMode), .manualLevel(manualLevel), .busy(busy),
    .halfTick(halfTick), .csLines(csLines), .setupDone(setupDone)
  );

  // Behavioural reference: phase 0 idle, 1 lead, 2 hold, 3 trail
  int         mPhase = 0;
  int         mIdx = 0;
  logic [3:0] expLines = 4'hF;
  logic       expSetup = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mIdx = 0; expLines = 4'hF;
    end else begin
      case (mPhase)
        0: if (busy && !manualMode) begin mPhase = 1; mIdx = csIndex; end
        1: if (halfTick) mPhase = 2;
        2: if (!busy) mPhase = 3;
        default: if (halfTick) mPhase = 0;
      endcase
      for (int i = 0; i < 4; i++) begin
        if (manualMode) expLines[i] = (i == csIndex) ? manualLevel : activeLow;
        else if (mPhase != 0 && i == mIdx) expLines[i] = ~activeLow;
        else expLines[i] = activeLow;
      end
    end
    expSetup = (mPhase == 2);
  end

  // R8: every-cycle comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (csLines !== expLines || setupDone !== expSetup) begin
        fails++;
        $display("FAIL %s model compare: lines=%b setup=%b expected lines=%b setup=%b",
                 manualMode ? "R7" : (mPhase != 0 ? "R3" : "R2"),
                 csLines, setupDone, expLines, expSetup);
      end
    end
  end

  task automatic expectNow(string tag, logic [3:0] lines, logic setup);
    checks++;
    if (csLines !== lines || setupDone !== setup) begin
      fails++;
      $display("FAIL %s: lines=%b setup=%b expected lines=%b setup=%b",
               tag, csLines, setupDone, lines, setup);
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    expectNow("R1 in reset", 4'hF, 1'b0);
    rstN = 1'b1;
    cyc(1);
    expectNow("R1 after reset", 4'hF, 1'b0);

    // automatic burst on line 1, active-low
    csIndex = 2'd1; busy = 1'b1;
    cyc(1);
    expectNow("R3 assert", 4'b1101, 1'b0);
    cyc(2);
    expectNow("R4 lead wait", 4'b1101, 1'b0);
    halfTick = 1'b1; cyc(1); halfTick = 1'b0;
    expectNow("R4 setup done", 4'b1101, 1'b1);
    csIndex = 2'd3; cyc(2);
    expectNow("R6 index held", 4'b1101, 1'b1);
    busy = 1'b0; cyc(1);
    expectNow("R5 trail hold", 4'b1101, 1'b0);
    cyc(2);
    expectNow("R5 still held", 4'b1101, 1'b0);
    halfTick = 1'b1; cyc(1); halfTick = 1'b0;
    expectNow("R5 release", 4'b1111, 1'b0);

    // active-high burst on line 2
    activeLow = 1'b0; csIndex = 2'd2; busy = 1'b1;
    cyc(1);
    expectNow("R3 active-high assert", 4'b0100, 1'b0);
    halfTick = 1'b1; cyc(1); halfTick = 1'b0; busy = 1'b0;
    cyc(1);
    halfTick = 1'b1; cyc(1); halfTick = 1'b0;
    expectNow("R2 idle low", 4'b0000, 1'b0);

    // manual mode: busy ignored, raw level
    manualMode = 1'b1; manualLevel = 1'b1; csIndex = 2'd2; busy = 1'b1;
    cyc(2);
    expectNow("R7 manual high", 4'b0100, 1'b0);
    activeLow = 1'b1; manualLevel = 1'b0;
    cyc(1);
    expectNow("R9 polarity flip", 4'b1011, 1'b0);
    csIndex = 2'd0; manualLevel = 1'b1;
    cyc(1);
    expectNow("R7 live index", 4'b1111, 1'b0);
    busy = 1'b0; manualMode = 1'b0;
    cyc(2);

    // mixed random run against the model
    for (int n = 0; n < 3000; n++) begin
      halfTick = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 9) == 0) busy = ~busy;
      if ($urandom_range(0, 15) == 0) csIndex = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 63) == 0) manualMode = ~manualMode;
      if ($urandom_range(0, 7) == 0) manualLevel = ~manualLevel;
      if ($urandom_range(0, 99) == 0) activeLow = ~activeLow;
      cyc(1);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule